// File: doc/BRIEF.md
# Watchdog Timer with Activity Reload

The block is a programmable watchdog. An 8-bit down counter is loaded by software and decrements once per time unit. The unit is either one second or one minute, and a control bit picks between them. A built-in prescaler divides the system clock into a one-second tick. In minute mode, a second divider passes on one tick in every sixty.

Software reaches the block through a small register port. Through it, software loads the count, sets the control bits, reads the live count and clears the timeout flag. Pulses from the keyboard and mouse interrupt lines count as signs of life. Each pulse restarts the countdown from the last value that software programmed.

When the count runs out, a sticky timeout flag is set. That flag drives two outputs, each with its own enable: an interrupt output and a request to blink an LED. The LED waveform generator and the address decode in front of the register port are outside this block.

Top module: `wdt_event_reload`

## Requirements
- R1: After reset the live count, the control register, the timeout flag, `irq_o` and `led_blink_o` are all 0.
- R2: Writing a non-zero value to register 0 (`wr_sel_i`=0) loads the counter with that value and stores it as the reload value. The write also clears the prescaler phase, so a full unit passes before the first decrement.
- R3: In second mode (control bit 0 clear), the counter drops by one every `CYC_PER_SEC` clock cycles. A count of N reaches 0 exactly N*`CYC_PER_SEC` cycles after the load edge.
- R4: In minute mode (control bit 0 set), the counter drops by one every `SECS_PER_MIN`*`CYC_PER_SEC` cycles.
- R5: A one-cycle pulse on `kbd_irq_i` or `mouse_irq_i` reloads the counter from the stored reload value and clears the prescaler phase, provided that the stored value is non-zero.
- R6: Writing 0 to register 0 stops the timer. The count stays 0, activity pulses are ignored and no timeout occurs.
- R7: When the counter steps from 1 to 0, status bit 0 (register 2) is set. The counter then holds at 0 and does not wrap.
- R8: Status bit 0 stays set until software writes register 2 with data bit 0 = 1. A write with data bit 0 = 0 leaves it set. A timeout in the same cycle as the clear wins.
- R9: `irq_o` is high exactly while status bit 0 and the interrupt enable (control bit 1) are both set.
- R10: `led_blink_o` is high exactly while status bit 0 and the LED enable (control bit 2) are both set.
- R11: `rd_data_o` returns the live count for `rd_sel_i`=0, the control bits {led_en, irq_en, minute} in bits 2:0 for `rd_sel_i`=1, and the status flag in bit 0 for `rd_sel_i`=2. All other bits, and `rd_sel_i`=3, read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one cycle |
| wr_sel_i | input | 2 | Write target: 0 count, 1 control, 2 status |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read select, combinational read |
| rd_data_o | output | 8 | Read data |
| kbd_irq_i | input | 1 | Keyboard activity pulse |
| mouse_irq_i | input | 1 | Mouse activity pulse |
| irq_o | output | 1 | Timeout interrupt |
| led_blink_o | output | 1 | LED blink request |

## Verification
The assertions assume that the activity inputs and the write strobe are synchronous to `clk_i` and last one cycle each. They also assume that a write presents a single select value for the whole cycle. The stimulus changes every input one time unit after a rising edge and drops each strobe again after exactly one edge. The prescaler is set short in the bench so that minute-mode timing can be covered within a short run. Activity pulses are applied both with a non-zero stored value and with a stopped timer.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_CTRL   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_NONE   = 2'd3
  } wdt_sel_e;

  typedef struct packed {
    logic led_en;
    logic irq_en;
    logic minute;
  } wdt_ctrl_t;

  localparam int unsigned CTRL_W = $bits(wdt_ctrl_t);
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned CYC_PER_SEC = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned W = (CYC_PER_SEC > 2) ? $clog2(CYC_PER_SEC) : 1;
  localparam logic [W-1:0] LAST = W'(CYC_PER_SEC - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/wdt_unit_div.sv
module wdt_unit_div #(
  parameter int unsigned SECS_PER_MIN = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sec_tick_i,
  input  logic minute_i,
  output logic unit_tick_o
);
  localparam int unsigned W = $clog2(SECS_PER_MIN);
  localparam logic [W-1:0] LAST = W'(SECS_PER_MIN - 1);

  logic [W-1:0] sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sec_q <= '0;
    else if (clr_i)   sec_q <= '0;
    else if (sec_tick_i) begin
      if (sec_q == LAST) sec_q <= '0;
      else               sec_q <= sec_q + 1'b1;
    end
  end

  assign unit_tick_o = minute_i ? (sec_tick_i && sec_q == LAST) : sec_tick_i;
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             unit_tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active;

  assign active = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (unit_tick_i && active) cnt_q <= cnt_q - 1'b1;
  end

  // one-cycle pulse on the 1 -> 0 step only; a held zero never re-fires
  assign expire_o = unit_tick_i && !load_i && (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/wdt_event_reload.sv
module wdt_event_reload
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W        = 8,
  parameter int unsigned CYC_PER_SEC  = 32768,
  parameter int unsigned SECS_PER_MIN = 60
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [1:0]       rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             kbd_irq_i,
  input  logic             mouse_irq_i,
  output logic             irq_o,
  output logic             led_blink_o
);
  logic             cnt_wr, ctrl_wr, stat_clr;
  logic             evt, evt_reload, reload;
  logic [CNT_W-1:0] reload_val_q, load_val, cnt;
  wdt_ctrl_t        ctrl_q;
  logic             status_q;
  logic             sec_tick, unit_tick, expire;

  assign cnt_wr     = wr_en_i && (wr_sel_i == SEL_COUNT);
  assign ctrl_wr    = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign stat_clr   = wr_en_i && (wr_sel_i == SEL_STATUS) && wr_data_i[0];
  assign evt        = kbd_irq_i || mouse_irq_i;
  assign evt_reload = evt && (reload_val_q != '0);
  assign reload     = cnt_wr || evt_reload;
  assign load_val   = cnt_wr ? wr_data_i : reload_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_val_q <= '0;
      ctrl_q       <= '0;
      status_q     <= 1'b0;
    end else begin
      if (cnt_wr)       reload_val_q <= wr_data_i;
      if (ctrl_wr)      ctrl_q       <= wdt_ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (expire)       status_q     <= 1'b1;
      else if (stat_clr) status_q    <= 1'b0;
    end
  end

  wdt_prescaler #(.CYC_PER_SEC(CYC_PER_SEC)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (reload),
    .tick_o (sec_tick)
  );

  wdt_unit_div #(.SECS_PER_MIN(SECS_PER_MIN)) u_unit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (reload),
    .sec_tick_i  (sec_tick),
    .minute_i    (ctrl_q.minute),
    .unit_tick_o (unit_tick)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (reload),
    .load_val_i  (load_val),
    .unit_tick_i (unit_tick),
    .cnt_o       (cnt),
    .expire_o    (expire)
  );

  assign irq_o       = status_q && ctrl_q.irq_en;
  assign led_blink_o = status_q && ctrl_q.led_en;

  always_comb begin
    rd_data_o = '0;
    case (rd_sel_i)
      SEL_COUNT:  rd_data_o = cnt;
      SEL_CTRL:   rd_data_o[CTRL_W-1:0] = ctrl_q;
      SEL_STATUS: rd_data_o[0] = status_q;
      default:    rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_event_reload_chk.sv
module wdt_event_reload_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_wr_i,
  input logic             evt_i,
  input logic             reload_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] reload_val_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             unit_tick_i,
  input logic             status_i,
  input logic             irq_en_i,
  input logic             led_en_i,
  input logic             irq_i,
  input logic             led_i
);
  AST_LOAD_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> cnt_i == $past(reload_val_i) || reload_val_i == cnt_i); // R2
  AST_DEC_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unit_tick_i && cnt_i != '0 && !reload_i) |=> cnt_i == $past(cnt_i) - CNT_W'(1)); // R3
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unit_tick_i && !reload_i) |=> $stable(cnt_i)); // R3
  AST_EVENT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !cnt_wr_i && reload_val_i != '0) |=> cnt_i == $past(reload_val_i)); // R5
  AST_STOPPED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && reload_val_i == '0 && !cnt_wr_i) |=> (cnt_i == '0 && !$rose(status_i))); // R6
  AST_TIMEOUT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == CNT_W'(1) && unit_tick_i && !reload_i) |=> status_i); // R7
  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && !reload_i) |=> cnt_i == '0); // R7
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i && !clr_i) |=> status_i); // R8
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (status_i && irq_en_i)); // R9
  AST_LED_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_i |-> (status_i && led_en_i)); // R10
endmodule

bind wdt_event_reload wdt_event_reload_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_wr_i     (cnt_wr),
  .evt_i        (evt),
  .reload_i     (reload),
  .clr_i        (stat_clr),
  .reload_val_i (reload_val_q),
  .cnt_i        (cnt),
  .unit_tick_i  (unit_tick),
  .status_i     (status_q),
  .irq_en_i     (ctrl_q.irq_en),
  .led_en_i     (ctrl_q.led_en),
  .irq_i        (irq_o),
  .led_i        (led_blink_o)
);

// File: tb/wdt_event_reload_tb.sv
`timescale 1ns/100ps
module wdt_event_reload_tb;
  localparam int unsigned P   = 4;
  localparam int unsigned MIN = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [7:0] rd_data;
  logic       kbd = 1'b0, mouse = 1'b0;
  logic       irq, led;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [9:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  wdt_event_reload #(.CNT_W(8), .CYC_PER_SEC(P), .SECS_PER_MIN(MIN)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .kbd_irq_i(kbd), .mouse_irq_i(mouse), .irq_o(irq), .led_blink_o(led)
  );

  // monitor: observed word is {irq, led, rd_data}
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if ({irq, led, rd_data} !== it.exp) begin
        errors++;
        $display("FAIL %s: got irq=%b led=%b data=%02h, expected irq=%b led=%b data=%02h",
                 it.tag, irq, led, rd_data, it.exp[9], it.exp[8], it.exp[7:0]);
      end
    end
  end

  function automatic logic [9:0] ob(input bit i, input bit l, input logic [7:0] d);
    return {i, l, d};
  endfunction

  task automatic chk(input logic [1:0] sel, input logic [9:0] e, input string tag);
    item_t it;
    #1 rd_sel = sel;
    it.exp = e;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    @(posedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(posedge clk);
    #1 wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic pulse(input bit use_mouse);
    @(posedge clk);
    #1 if (use_mouse) mouse = 1'b1; else kbd = 1'b1;
    @(posedge clk);
    #1 mouse = 1'b0; kbd = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    #1 rst_n = 1'b1;
    @(posedge clk);
    chk(2'd0, ob(0,0,8'h00), "R1 count after reset");
    chk(2'd1, ob(0,0,8'h00), "R1 ctrl after reset");
    chk(2'd2, ob(0,0,8'h00), "R1 status after reset");
    chk(2'd3, ob(0,0,8'h00), "R11 unused select");

    // second mode, irq+led enabled
    wr(2'd1, 8'h06);
    chk(2'd1, ob(0,0,8'h06), "R11 ctrl readback");
    wr(2'd0, 8'd3);
    chk(2'd0, ob(0,0,8'd3), "R2 load on write");
    wait_cyc(3);
    chk(2'd0, ob(0,0,8'd2), "R3 first decrement");
    wait_cyc(6);
    chk(2'd2, ob(0,0,8'h00), "R3 no timeout one cycle early");
    chk(2'd2, ob(1,1,8'h01), "R7 R9 R10 timeout");
    wait_cyc(20);
    chk(2'd0, ob(1,1,8'h00), "R7 hold at zero");
    wr(2'd2, 8'h00);
    chk(2'd2, ob(1,1,8'h01), "R8 write zero keeps flag");
    wr(2'd2, 8'h01);
    chk(2'd2, ob(0,0,8'h00), "R8 write one clears flag");

    // activity reload
    wr(2'd0, 8'd5);
    wait_cyc(8);
    chk(2'd0, ob(0,0,8'd3), "R3 two decrements");
    pulse(1'b0);
    chk(2'd0, ob(0,0,8'd5), "R5 keyboard reload");
    wait_cyc(3);
    chk(2'd0, ob(0,0,8'd4), "R5 decrement after keyboard reload");
    pulse(1'b1);
    chk(2'd0, ob(0,0,8'd5), "R5 mouse reload");
    wait_cyc(2);
    chk(2'd0, ob(0,0,8'd5), "R5 prescaler phase cleared");
    chk(2'd0, ob(0,0,8'd4), "R5 full unit after mouse reload");

    // stop with zero
    wr(2'd0, 8'd0);
    chk(2'd0, ob(0,0,8'd0), "R6 zero write stops");
    wait_cyc(40);
    chk(2'd2, ob(0,0,8'h00), "R6 no timeout while stopped");
    pulse(1'b0);
    chk(2'd0, ob(0,0,8'd0), "R6 keyboard ignored when stopped");
    pulse(1'b1);
    chk(2'd2, ob(0,0,8'h00), "R6 mouse ignored when stopped");

    // enables separate from flag
    wr(2'd1, 8'h00);
    wr(2'd0, 8'd1);
    wait_cyc(3);
    chk(2'd2, ob(0,0,8'h00), "R7 before timeout");
    chk(2'd2, ob(0,0,8'h01), "R9 R10 flag without enables");
    wr(2'd1, 8'h02);
    chk(2'd2, ob(1,0,8'h01), "R9 irq follows enable");
    wr(2'd1, 8'h04);
    chk(2'd2, ob(0,1,8'h01), "R10 led follows enable");
    wr(2'd2, 8'h01);
    chk(2'd2, ob(0,0,8'h00), "R8 clear");

    // minute mode with irq
    wr(2'd1, 8'h03);
    wr(2'd0, 8'd2);
    wait_cyc(239);
    chk(2'd0, ob(0,0,8'd2), "R4 no decrement before a minute");
    chk(2'd0, ob(0,0,8'd1), "R4 decrement at a minute");
    wait_cyc(238);
    chk(2'd2, ob(0,0,8'h00), "R4 no timeout early");
    chk(2'd2, ob(1,0,8'h01), "R4 R9 minute timeout");
    wr(2'd2, 8'h01);

    // rewrite during countdown
    wr(2'd1, 8'h00);
    wr(2'd0, 8'd4);
    wait_cyc(6);
    chk(2'd0, ob(0,0,8'd3), "R3 countdown running");
    wr(2'd0, 8'd7);
    chk(2'd0, ob(0,0,8'd7), "R2 rewrite reloads");
    wait_cyc(2);
    chk(2'd0, ob(0,0,8'd7), "R2 prescaler phase cleared");
    chk(2'd0, ob(0,0,8'd6), "R2 full unit after rewrite");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule